// File: doc/BRIEF.md
# Spilling Label Stack with Process Context Save

This block keeps a last-in first-out stack of return labels on chip. Labels are pushed when a call is set up, and popped or peeked when a return is checked. The on-chip store holds `DEPTH` entries. When a push finds the store full, the oldest half of the entries goes out to a backing memory and the newer half slides down, so the push can complete. When a pop or peek finds the store empty while blocks remain in memory, the most recently spilled half-block is read back first. Spilled blocks sit in a per-process region that starts at `procBase`. Each spill moves the write address up by `DEPTH/2` words, and each refill moves it back down by the same amount.

The block also holds a label register. On a process switch it can write its whole state to memory as an image: pointer, spill count, label register and all entries. It can also load such an image back in. If the incoming process does not use enforcement, the block is cleared and goes inactive. All memory traffic uses one word-wide request port. Each transfer holds its request until the memory acknowledges it.

Top module: `label_spill_stack`

## Requirements
- R1: A request with `reqOp` 2'b00 pushes `reqLabel`. A request with 2'b01 pops. 2'b10 peeks, and the reserved code 2'b11 also peeks. A request is accepted on a clock edge where `reqValid` and `reqReady` are both high. One cycle after a pop or peek is accepted, `rspValid` is high for one cycle and `rspLabel` holds the most recent label not yet popped. A peek leaves the stack unchanged.
- R2: A pop or peek on an empty stack with a spill count of zero is accepted at once. It answers with `rspEmpty` = 1 and causes no memory traffic.
- R3: A push that finds `DEPTH` entries on chip is stalled (`reqReady` low) while the block works. First it writes entry i, for i from 0 up to `DEPTH/2`-1 (entry 0 is the oldest), to address `procBase + count*DEPTH/2 + i`. Then it moves the upper half down, sets the pointer to `DEPTH/2` and increments the spill count. After that the push completes.
- R4: A pop or peek that finds no entries on chip and a nonzero spill count is stalled while the block refills. It reads address `procBase + (count-1)*DEPTH/2 + i` into entry i for each i below `DEPTH/2`. Then it sets the pointer to `DEPTH/2` and decrements the count. After that the pop or peek completes.
- R5: While `memReq` is high and `memAck` is low, `memAddr`, `memWe` and `memWdata` hold steady. Exactly one word moves on each edge where `memReq` and `memAck` are both high. For a read, data is taken from `memRdata` on that edge.
- R6: `reqReady` is low whenever a spill, refill, save or restore is in progress. It is also low in any cycle where `ctxValid` is high. A context command is taken only when the block is idle.
- R7: A context command with `ctxSaveEn` high writes a `DEPTH`+3 word image starting at `ctxSaveBase`. Word 0 is the pointer, word 1 is the spill count, word 2 is the label register, and word 3+i is entry i.
- R8: When `ctxRestoreEn` is high, the command (after any save) reads an image in the same layout from `ctxRestoreBase` and sets `enforceOn`. Later pops return the restored labels, including those in its spilled blocks.
- R9: When `ctxRestoreEn` is low, the command clears the pointer, spill count and label register and drops `enforceOn`. While the block is inactive, pushes and label register writes have no effect, and pops and peeks answer empty.
- R10: `ctxDone` is a one-cycle pulse. It comes in the cycle after the final image word is acknowledged, or in the cycle after the command is accepted if there is nothing to transfer.
- R11: After reset, the pointer, spill count and label register are zero, `enforceOn` is high, `reqReady` is high and `memReq` is low.
- R12: When the block is idle and active, `lsrWe` loads `lsrData` into the label register on that edge, and `lsrValue` shows the new value from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Stack request valid |
| reqOp | input | 2 | 00 push, 01 pop, 10 peek, 11 peek |
| reqLabel | input | LABEL_W | Label to push |
| reqReady | output | 1 | Request can be accepted this cycle |
| rspValid | output | 1 | Pop/peek result valid |
| rspLabel | output | LABEL_W | Returned label |
| rspEmpty | output | 1 | Pop/peek found no label |
| lsrWe | input | 1 | Label register write |
| lsrData | input | LABEL_W | Label register write data |
| lsrValue | output | LABEL_W | Label register contents |
| ctxValid | input | 1 | Context switch command |
| ctxSaveEn | input | 1 | Outgoing process has enforcement on |
| ctxRestoreEn | input | 1 | Incoming process has enforcement on |
| ctxSaveBase | input | ADDR_W | Image address for the save |
| ctxRestoreBase | input | ADDR_W | Image address for the restore |
| ctxDone | output | 1 | Context switch finished pulse |
| procBase | input | ADDR_W | Spill region base of the running process |
| enforceOn | output | 1 | Stack is active |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Memory request is a write |
| memAddr | output | ADDR_W | Memory word address |
| memWdata | output | LABEL_W | Memory write data |
| memAck | input | 1 | Memory accepts the request this cycle |
| memRdata | input | LABEL_W | Memory read data, valid with memAck |

## Verification
A wrong pointer shows up on the next pop as a wrong label or a false empty flag. A wrong spill count is quieter: nothing is wrong at the ports until the next spill or refill, which then goes to an address one half-block off. In that case the refilled labels differ from the pushed ones after up to `DEPTH/2` further pops. A bad shift or refill index corrupts labels that only come back after the stack drains through that block. For this reason the stimulus drains the stack fully many times over. A save/restore fault shows in the image words as soon as `ctxDone` pulses, and in the popped labels once the restored process runs.

// File: rtl/lss_pkg.sv
package lss_pkg;

  typedef enum logic [1:0] {
    OP_PUSH = 2'd0,
    OP_POP  = 2'd1,
    OP_PEEK = 2'd2,
    OP_RSVD = 2'd3
  } stackOp_e;

  typedef enum logic [2:0] {
    MEM_NONE,
    MEM_SPILL,
    MEM_REFILL,
    MEM_SAVE,
    MEM_RESTORE
  } memMode_e;

  typedef struct packed {
    logic     doPush;
    logic     doPop;
    logic     doRsp;
    logic     lsrLoad;
    logic     shiftDown;
    logic     refillWr;
    logic     refillLast;
    logic     ctxStart;
    logic     ctxLoad;
    logic     ctxClear;
    logic     ctxActivate;
    memMode_e mode;
  } lssStrobe_t;

endpackage

// File: rtl/lss_ctrl.sv
module lss_ctrl
  import lss_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PTR_W = 4,
  parameter int CNT_W = 8,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqOp,
  input  logic             ctxValid,
  input  logic             ctxSaveEn,
  input  logic             ctxRestoreEn,
  input  logic             lsrWe,
  input  logic             memAck,
  input  logic [PTR_W-1:0] ptr,
  input  logic [CNT_W-1:0] spillCnt,
  input  logic             active,
  output logic             reqReady,
  output logic             ctxDone,
  output lssStrobe_t       strobe,
  output logic [IDX_W-1:0] idx
);

  localparam int HALF = DEPTH / 2;
  localparam int IMG  = DEPTH + 3;

  typedef enum logic [2:0] {
    S_IDLE, S_SPILL, S_SHIFT, S_REFILL, S_SAVE, S_RESTORE, S_END
  } ctrlState_e;

  ctrlState_e state;
  logic       restoreFlag;
  logic       isPush, needSpill, needRefill, accept;
  logic       lastHalf, lastImg;

  always_comb begin
    isPush     = (reqOp == OP_PUSH);
    needSpill  = active && isPush && (ptr == PTR_W'(DEPTH));
    needRefill = active && !isPush && (ptr == '0) && (spillCnt != '0);
    reqReady   = (state == S_IDLE) && !ctxValid && !needSpill && !needRefill;
    accept     = reqValid && reqReady;
    lastHalf   = (idx == IDX_W'(HALF - 1));
    lastImg    = (idx == IDX_W'(IMG - 1));
    ctxDone    = (state == S_END);

    strobe             = '0;
    strobe.mode        = MEM_NONE;
    strobe.doPush      = accept && isPush && active;
    strobe.doPop       = accept && (reqOp == OP_POP) && active;
    strobe.doRsp       = accept && !isPush;
    strobe.lsrLoad     = (state == S_IDLE) && !ctxValid && lsrWe && active;
    strobe.ctxStart    = (state == S_IDLE) && ctxValid;
    case (state)
      S_SPILL:   strobe.mode = MEM_SPILL;
      S_SHIFT:   strobe.shiftDown = 1'b1;
      S_REFILL: begin
        strobe.mode       = MEM_REFILL;
        strobe.refillWr   = memAck;
        strobe.refillLast = memAck && lastHalf;
      end
      S_SAVE:    strobe.mode = MEM_SAVE;
      S_RESTORE: begin
        strobe.mode    = MEM_RESTORE;
        strobe.ctxLoad = memAck;
      end
      S_END: begin
        strobe.ctxClear    = !restoreFlag;
        strobe.ctxActivate = restoreFlag;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= S_IDLE;
      idx         <= '0;
      restoreFlag <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          idx <= '0;
          if (ctxValid) begin
            restoreFlag <= ctxRestoreEn;
            if (ctxSaveEn)         state <= S_SAVE;
            else if (ctxRestoreEn) state <= S_RESTORE;
            else                   state <= S_END;
          end else if (reqValid && needSpill) begin
            state <= S_SPILL;
          end else if (reqValid && needRefill) begin
            state <= S_REFILL;
          end
        end
        S_SPILL: if (memAck) begin
          if (lastHalf) begin idx <= '0; state <= S_SHIFT; end
          else idx <= idx + 1'b1;
        end
        S_SHIFT: state <= S_IDLE;
        S_REFILL: if (memAck) begin
          if (lastHalf) begin idx <= '0; state <= S_IDLE; end
          else idx <= idx + 1'b1;
        end
        S_SAVE: if (memAck) begin
          if (lastImg) begin
            idx   <= '0;
            state <= restoreFlag ? S_RESTORE : S_END;
          end else idx <= idx + 1'b1;
        end
        S_RESTORE: if (memAck) begin
          if (lastImg) begin idx <= '0; state <= S_END; end
          else idx <= idx + 1'b1;
        end
        S_END:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lss_dp.sv
module lss_dp
  import lss_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int LABEL_W = 16,
  parameter int ADDR_W  = 16,
  parameter int PTR_W   = 4,
  parameter int CNT_W   = 8,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  lssStrobe_t         strobe,
  input  logic [IDX_W-1:0]   idx,
  input  logic [LABEL_W-1:0] reqLabel,
  input  logic [LABEL_W-1:0] lsrData,
  input  logic [LABEL_W-1:0] memRdata,
  input  logic [ADDR_W-1:0]  procBase,
  input  logic [ADDR_W-1:0]  ctxSaveBase,
  input  logic [ADDR_W-1:0]  ctxRestoreBase,
  output logic [PTR_W-1:0]   ptr,
  output logic [CNT_W-1:0]   spillCnt,
  output logic               active,
  output logic [LABEL_W-1:0] lsrValue,
  output logic               rspValid,
  output logic [LABEL_W-1:0] rspLabel,
  output logic               rspEmpty,
  output logic               memReq,
  output logic               memWe,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [LABEL_W-1:0] memWdata
);

  localparam int HALF   = DEPTH / 2;
  localparam int SLOT_W = $clog2(DEPTH);

  logic [LABEL_W-1:0] entry [DEPTH];
  logic [ADDR_W-1:0]  saveBaseQ, restoreBaseQ;
  logic [SLOT_W-1:0]  topSlot, idxSlot, imgSlot;
  logic [ADDR_W-1:0]  spillOff, refillOff;

  assign topSlot = SLOT_W'(ptr - 1'b1);
  assign idxSlot = SLOT_W'(idx);
  assign imgSlot = SLOT_W'(idx - IDX_W'(3));

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    logic [LABEL_W-1:0] shiftVal;
    if (e < HALF) begin : g_low
      assign shiftVal = entry[e + HALF];
    end else begin : g_high
      assign shiftVal = entry[e];
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                       entry[e] <= '0;
      else if (strobe.shiftDown)                       entry[e] <= shiftVal;
      else if (strobe.refillWr && idx == IDX_W'(e))    entry[e] <= memRdata;
      else if (strobe.ctxLoad && idx == IDX_W'(e + 3)) entry[e] <= memRdata;
      else if (strobe.doPush && ptr == PTR_W'(e))      entry[e] <= reqLabel;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr          <= '0;
      spillCnt     <= '0;
      lsrValue     <= '0;
      active       <= 1'b1;
      saveBaseQ    <= '0;
      restoreBaseQ <= '0;
    end else begin
      if (strobe.ctxStart) begin
        saveBaseQ    <= ctxSaveBase;
        restoreBaseQ <= ctxRestoreBase;
      end
      if (strobe.doPush) ptr <= ptr + 1'b1;
      else if (strobe.doPop && ptr != '0) ptr <= ptr - 1'b1;
      else if (strobe.shiftDown) begin
        ptr      <= PTR_W'(HALF);
        spillCnt <= spillCnt + 1'b1;
      end else if (strobe.refillLast) begin
        ptr      <= PTR_W'(HALF);
        spillCnt <= spillCnt - 1'b1;
      end else if (strobe.ctxLoad) begin
        if (idx == IDX_W'(0)) ptr      <= PTR_W'(memRdata);
        if (idx == IDX_W'(1)) spillCnt <= CNT_W'(memRdata);
        if (idx == IDX_W'(2)) lsrValue <= memRdata;
      end else if (strobe.ctxClear) begin
        ptr      <= '0;
        spillCnt <= '0;
        lsrValue <= '0;
        active   <= 1'b0;
      end else if (strobe.ctxActivate) begin
        active <= 1'b1;
      end
      if (strobe.lsrLoad) lsrValue <= lsrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspEmpty <= 1'b0;
      rspLabel <= '0;
    end else begin
      rspValid <= strobe.doRsp;
      if (strobe.doRsp) begin
        rspEmpty <= !active || (ptr == '0);
        rspLabel <= (!active || ptr == '0) ? '0 : entry[topSlot];
      end
    end
  end

  always_comb begin
    spillOff  = ADDR_W'(spillCnt) * ADDR_W'(HALF);
    refillOff = (ADDR_W'(spillCnt) - 1'b1) * ADDR_W'(HALF);
    memReq    = (strobe.mode != MEM_NONE);
    memWe     = (strobe.mode == MEM_SPILL) || (strobe.mode == MEM_SAVE);
    memAddr   = '0;
    memWdata  = '0;
    case (strobe.mode)
      MEM_SPILL: begin
        memAddr  = procBase + spillOff + ADDR_W'(idx);
        memWdata = entry[idxSlot];
      end
      MEM_REFILL:  memAddr = procBase + refillOff + ADDR_W'(idx);
      MEM_SAVE: begin
        memAddr = saveBaseQ + ADDR_W'(idx);
        if (idx == IDX_W'(0))      memWdata = LABEL_W'(ptr);
        else if (idx == IDX_W'(1)) memWdata = LABEL_W'(spillCnt);
        else if (idx == IDX_W'(2)) memWdata = lsrValue;
        else                       memWdata = entry[imgSlot];
      end
      MEM_RESTORE: memAddr = restoreBaseQ + ADDR_W'(idx);
      default: ;
    endcase
  end

endmodule

// File: rtl/label_spill_stack.sv
module label_spill_stack
  import lss_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int LABEL_W = 16,
  parameter int ADDR_W  = 16,
  parameter int CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [1:0]         reqOp,
  input  logic [LABEL_W-1:0] reqLabel,
  output logic               reqReady,
  output logic               rspValid,
  output logic [LABEL_W-1:0] rspLabel,
  output logic               rspEmpty,
  input  logic               lsrWe,
  input  logic [LABEL_W-1:0] lsrData,
  output logic [LABEL_W-1:0] lsrValue,
  input  logic               ctxValid,
  input  logic               ctxSaveEn,
  input  logic               ctxRestoreEn,
  input  logic [ADDR_W-1:0]  ctxSaveBase,
  input  logic [ADDR_W-1:0]  ctxRestoreBase,
  output logic               ctxDone,
  input  logic [ADDR_W-1:0]  procBase,
  output logic               enforceOn,
  output logic               memReq,
  output logic               memWe,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [LABEL_W-1:0] memWdata,
  input  logic               memAck,
  input  logic [LABEL_W-1:0] memRdata
);

  localparam int PTR_W = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH + 3);

  lssStrobe_t       strobe;
  logic [IDX_W-1:0] wordIdx;
  logic [PTR_W-1:0] stPtr;
  logic [CNT_W-1:0] stCnt;

  lss_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .ctxValid(ctxValid), .ctxSaveEn(ctxSaveEn), .ctxRestoreEn(ctxRestoreEn),
    .lsrWe(lsrWe), .memAck(memAck), .ptr(stPtr), .spillCnt(stCnt),
    .active(enforceOn), .reqReady(reqReady), .ctxDone(ctxDone),
    .strobe(strobe), .idx(wordIdx)
  );

  lss_dp #(.DEPTH(DEPTH), .LABEL_W(LABEL_W), .ADDR_W(ADDR_W), .PTR_W(PTR_W),
           .CNT_W(CNT_W), .IDX_W(IDX_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .idx(wordIdx),
    .reqLabel(reqLabel), .lsrData(lsrData), .memRdata(memRdata),
    .procBase(procBase), .ctxSaveBase(ctxSaveBase), .ctxRestoreBase(ctxRestoreBase),
    .ptr(stPtr), .spillCnt(stCnt), .active(enforceOn), .lsrValue(lsrValue),
    .rspValid(rspValid), .rspLabel(rspLabel), .rspEmpty(rspEmpty),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata)
  );

endmodule

// File: rtl/lss_checker.sv
module lss_checker #(
  parameter int DEPTH   = 8,
  parameter int LABEL_W = 16,
  parameter int ADDR_W  = 16,
  parameter int PTR_W   = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic               reqReady,
  input logic [1:0]         reqOp,
  input logic               rspValid,
  input logic               ctxDone,
  input logic               memReq,
  input logic               memAck,
  input logic               memWe,
  input logic [ADDR_W-1:0]  memAddr,
  input logic [LABEL_W-1:0] memWdata,
  input logic [PTR_W-1:0]   ptr
);

  // R5: a pending transfer keeps its address, direction and data
  a_r5_hold_request: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata));

  // R6: no stack request is taken while memory traffic runs
  a_r6_no_accept_busy: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !reqReady);

  // R6: the closing cycle of a context switch is busy too
  a_r6_done_busy: assert property (@(posedge clk) disable iff (!rstN)
    ctxDone |-> !reqReady && !memReq);

  // R10: completion is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    ctxDone |=> !ctxDone);

  // R1: a response follows only an accepted pop or peek
  a_r1_rsp_follows_accept: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(reqValid && reqReady && reqOp != 2'b00));

  // R3: the on-chip pointer never passes the depth
  a_r3_ptr_bound: assert property (@(posedge clk) disable iff (!rstN)
    ptr <= PTR_W'(DEPTH));

endmodule

bind label_spill_stack lss_checker #(
  .DEPTH(DEPTH), .LABEL_W(LABEL_W), .ADDR_W(ADDR_W), .PTR_W($clog2(DEPTH + 1))
) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqOp(reqOp),
  .rspValid(rspValid), .ctxDone(ctxDone), .memReq(memReq), .memAck(memAck),
  .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata), .ptr(stPtr)
);

// File: tb/label_spill_stack_tb_top.sv
`timescale 1ns/1ps
module label_spill_stack_tb_top;

  localparam int N    = 8;
  localparam int HALF = N / 2;
  localparam int LW   = 16;
  localparam int AW   = 16;
  localparam logic [AW-1:0] PBASE = 16'h0100;
  localparam logic [AW-1:0] IMGA  = 16'h0400;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 0, lsrWe = 0, ctxValid = 0, ctxSaveEn = 0, ctxRestoreEn = 0, memAck = 0;
  logic [1:0] reqOp = 0;
  logic [LW-1:0] reqLabel = 0, lsrData = 0;
  logic [AW-1:0] ctxSaveBase = 0, ctxRestoreBase = 0, procBase = PBASE;
  logic reqReady, rspValid, rspEmpty, ctxDone, enforceOn, memReq, memWe;
  logic [LW-1:0] rspLabel, lsrValue, memWdata, memRdata;
  logic [AW-1:0] memAddr;

  always #2 clk = ~clk;

  label_spill_stack #(.DEPTH(N), .LABEL_W(LW), .ADDR_W(AW), .CNT_W(8)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqLabel(reqLabel),
    .reqReady(reqReady), .rspValid(rspValid), .rspLabel(rspLabel), .rspEmpty(rspEmpty),
    .lsrWe(lsrWe), .lsrData(lsrData), .lsrValue(lsrValue), .ctxValid(ctxValid),
    .ctxSaveEn(ctxSaveEn), .ctxRestoreEn(ctxRestoreEn), .ctxSaveBase(ctxSaveBase),
    .ctxRestoreBase(ctxRestoreBase), .ctxDone(ctxDone), .procBase(procBase),
    .enforceOn(enforceOn), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata)
  );

  // backing memory
  logic [LW-1:0] mem [4096];
  initial for (int i = 0; i < 4096; i++) mem[i] = '0;
  assign memRdata = mem[memAddr[11:0]];
  always @(posedge clk) if (memReq && memAck && memWe) mem[memAddr[11:0]] <= memWdata;
  always @(negedge clk) memAck <= ($urandom_range(3) != 0);

  int checks = 0, failures = 0, hsErrors = 0;

  // R5 monitor: a held request must not change before it is acknowledged
  logic pendPrev = 0;
  logic [AW-1:0] addrPrev;
  logic [LW-1:0] dataPrev;
  logic wePrev;
  always @(posedge clk) begin
    if (rstN && pendPrev && !(memReq && memAddr == addrPrev && memWe == wePrev && memWdata == dataPrev))
      hsErrors++;
    pendPrev <= memReq && !memAck;
    addrPrev <= memAddr; wePrev <= memWe; dataPrev <= memWdata;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model
  logic [LW-1:0] q[$];
  int mPtr = 0, mCnt = 0;
  logic [LW-1:0] mLsr = 0;
  bit mActive = 1;
  logic [LW-1:0] sQ[$];
  int sPtr, sCnt;
  logic [LW-1:0] sLsr;

  task automatic issue(input logic [1:0] op, input logic [LW-1:0] lab, output int waits);
    waits = 0;
    reqValid = 1; reqOp = op; reqLabel = lab; #1;
    while (!reqReady) begin @(negedge clk); #1; waits++; end
    @(posedge clk); @(negedge clk);
    reqValid = 0;
  endtask

  task automatic pushOp(input logic [LW-1:0] lab);
    int waits, c0, qs;
    bit spill;
    spill = mActive && mPtr == N; c0 = mCnt; qs = q.size();
    issue(2'b00, lab, waits);
    if (spill) begin
      check(waits > 0, "R3", "push at full not stalled", waits, 1);
      for (int i = 0; i < HALF; i++)
        check(mem[12'(PBASE + c0 * HALF + i)] == q[qs - N + i], "R3", "spilled word",
              mem[12'(PBASE + c0 * HALF + i)], q[qs - N + i]);
      mPtr = HALF; mCnt++;
    end
    if (mActive) begin q.push_back(lab); mPtr++; end
  endtask

  task automatic popOp(input logic [1:0] op);
    int waits;
    bit refill, emp;
    logic [LW-1:0] expLab;
    refill = mActive && mPtr == 0 && mCnt > 0;
    emp = !mActive || q.size() == 0;
    expLab = emp ? '0 : q[$];
    issue(op, 16'h0, waits);
    check(rspValid == 1'b1, "R1", "rspValid", rspValid, 1);
    check(rspEmpty == emp, emp ? "R2" : "R1", "rspEmpty", rspEmpty, emp);
    if (emp && mActive) check(waits == 0, "R2", "empty pop stalled", waits, 0);
    if (!emp) begin
      check(rspLabel == expLab, refill ? "R4" : "R1", "rspLabel", rspLabel, expLab);
      if (refill) begin
        check(waits > 0, "R4", "refill not stalled", waits, 1);
        mPtr = HALF; mCnt--;
      end
      if (op == 2'b01) begin void'(q.pop_back()); mPtr--; end
    end
  endtask

  task automatic lsrOp(input logic [LW-1:0] d);
    lsrWe = 1; lsrData = d;
    @(posedge clk); @(negedge clk);
    lsrWe = 0;
    if (mActive) mLsr = d;
    check(lsrValue == mLsr, mActive ? "R12" : "R9", "lsrValue", lsrValue, mLsr);
  endtask

  task automatic ctxOp(input bit sv, input bit rs, input logic [AW-1:0] sb, input logic [AW-1:0] rb);
    int n = 0;
    ctxValid = 1; ctxSaveEn = sv; ctxRestoreEn = rs; ctxSaveBase = sb; ctxRestoreBase = rb;
    #1;
    check(reqReady == 1'b0, "R6", "ready during ctx command", reqReady, 0);
    @(posedge clk); @(negedge clk);
    ctxValid = 0;
    while (!ctxDone && n < 500) begin @(negedge clk); n++; end
    check(ctxDone == 1'b1, "R10", "ctxDone", ctxDone, 1);
    if (!sv && !rs) check(n == 0, "R10", "done delay", n, 0);
    @(negedge clk);
    check(ctxDone == 1'b0, "R10", "done width", ctxDone, 0);
    if (sv) begin
      check(mem[12'(sb)] == LW'(mPtr), "R7", "image ptr", mem[12'(sb)], mPtr);
      check(mem[12'(sb + 1)] == LW'(mCnt), "R7", "image count", mem[12'(sb + 1)], mCnt);
      check(mem[12'(sb + 2)] == mLsr, "R7", "image lsr", mem[12'(sb + 2)], mLsr);
      for (int i = 0; i < mPtr; i++)
        check(mem[12'(sb + 3 + i)] == q[q.size() - mPtr + i], "R7", "image entry",
              mem[12'(sb + 3 + i)], q[q.size() - mPtr + i]);
      sQ = q; sPtr = mPtr; sCnt = mCnt; sLsr = mLsr;
    end
    if (rs) begin
      q = sQ; mPtr = sPtr; mCnt = sCnt; mLsr = sLsr; mActive = 1;
      check(enforceOn == 1'b1, "R8", "enforceOn", enforceOn, 1);
      check(lsrValue == mLsr, "R8", "restored lsr", lsrValue, mLsr);
    end else begin
      q.delete(); mPtr = 0; mCnt = 0; mLsr = 0; mActive = 0;
      check(enforceOn == 1'b0, "R9", "enforceOn", enforceOn, 0);
      check(lsrValue == 16'h0, "R9", "lsr cleared", lsrValue, 0);
    end
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int r;
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk); #1;
    // R11 reset state
    check(reqReady == 1'b1, "R11", "reqReady", reqReady, 1);
    check(memReq == 1'b0, "R11", "memReq", memReq, 0);
    check(enforceOn == 1'b1, "R11", "enforceOn", enforceOn, 1);
    check(lsrValue == 16'h0, "R11", "lsrValue", lsrValue, 0);
    check(rspValid == 1'b0, "R11", "rspValid", rspValid, 0);

    // R2 empty pop and peek, no memory traffic
    popOp(2'b01);
    check(memReq == 1'b0, "R2", "memReq after empty pop", memReq, 0);
    popOp(2'b10);

    // R3/R4 directed: fill, spill twice, drain through refills
    for (int i = 0; i < 2 * N + 1; i++) pushOp(LW'(16'h1000 + i));
    popOp(2'b10);
    popOp(2'b11);
    for (int i = 0; i < 2 * N + 2; i++) popOp(2'b01);

    // R12 label register
    lsrOp(16'h3C3C);

    // random mix
    for (int k = 0; k < 600; k++) begin
      r = $urandom_range(99);
      if (r < 55)      pushOp(LW'($urandom));
      else if (r < 85) popOp(2'b01);
      else if (r < 93) popOp(2'b10);
      else if (r < 96) popOp(2'b11);
      else             lsrOp(LW'($urandom));
    end
    // make sure there is spilled state to carry across the switch
    for (int i = 0; i < N + 3; i++) pushOp(LW'(16'hA000 + i));
    lsrOp(16'hA5A5);

    // R7/R9: save and disable
    ctxOp(1'b1, 1'b0, IMGA, 16'h0);
    pushOp(16'hDEAD);
    popOp(2'b01);
    popOp(2'b10);
    lsrOp(16'hBEEF);

    // R8: restore the saved process and drain it completely
    ctxOp(1'b0, 1'b1, 16'h0, IMGA);
    while (q.size() > 0) popOp(2'b01);
    popOp(2'b01);

    // R10: switch with nothing to move
    ctxOp(1'b0, 1'b0, 16'h0, 16'h0);

    check(hsErrors == 0, "R5", "handshake changes while pending", hsErrors, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule